// File: doc/BRIEF.md
# Point-Plot Display Controller

This block sits on a processor's I/O instruction path and drives a point-plotting display. A one-cycle command strobe carries a 12-bit I/O instruction word. The controller acts only when the word's top three bits are octal 6 and its device field matches `DEV_ID`. The low three bits then select one of eight functions. These functions latch X or Y deflection values from the accumulator, fire an intensify pulse at the current position, load or read a mode register, and manage a completion flag that software can poll with a skip.

Each timed operation drops the completion flag and starts a countdown. The flag rises again when the countdown ends. The countdown length depends on the operation: a coordinate load, an intensify, a screen erase, a switch to red, and a switch to green each have their own parameter. An interrupt request is raised while interrupts are enabled and the flag is set.

Top module: `pt_display_ctl`

## Requirements
- R1: After reset, `done`, `irq`, `x_pos`, `y_pos` and all mode bits are 0, and a status read returns 0.
- R2: Function 3 loads `x_pos` from `ac_in` and function 4 loads `y_pos` from `ac_in`. Either one clears `done` on the next edge, and `done` rises exactly `MOVE_DLY` edges after the command edge.
- R3: Function 5 raises `intens_pls` for exactly one cycle after the command edge. It clears `done`, and `done` rises exactly `INTENS_DLY` edges after the command edge.
- R4: During function 2, `skip` is high if and only if `done` is set. Function 1 clears `done`, so a skip issued after it does not skip.
- R5: Function 6 writes mode bits from `ac_in`: bit 0 is interrupt enable, bit 1 is channel, bit 2 is colour (1 = red), bit 4 is store and bit 5 is write-through. `ac_clr` is high during the command.
- R6: Function 7 drives `ac_drive` high with the status on `ac_out`. The mode bits sit at the positions given in R5, `done` is at bit 11, and all other bits read 0.
- R7: A function 6 with `ac_in` bit 3 set starts an erase. `erase_pls` pulses for one cycle, `done` clears, and `done` rises `ERASE_DLY` edges after the command edge. The erase bit is never stored and always reads 0.
- R8: A function 6 that changes the colour bit, without erase, clears `done`. `done` rises after `RED_DLY` edges when the new colour is red and after `GREEN_DLY` edges when it is green. If the colour bit does not change, `done` is left as it is.
- R9: `irq` is high exactly when interrupt enable and `done` are both set.
- R10: Function 0 clears `x_pos`, `y_pos`, all mode bits and `done`, and cancels any pending countdown.
- R11: A command whose device field differs from `DEV_ID` changes no register and asserts no output.
- R12: A timed command issued while a countdown is running restarts the countdown with the new command's delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction strobe, one cycle per command |
| cmd_op | input | 12 | Instruction word |
| ac_in | input | 12 | Accumulator value presented with the command |
| ac_out | output | 12 | Status word during a read, 0 otherwise |
| ac_drive | output | 1 | `ac_out` is valid this cycle |
| ac_clr | output | 1 | Request to clear the accumulator |
| skip | output | 1 | Skip the next instruction |
| x_pos | output | 12 | X deflection register |
| y_pos | output | 12 | Y deflection register |
| intens_pls | output | 1 | Intensify pulse |
| erase_pls | output | 1 | Erase start pulse |
| chan_sel | output | 1 | Channel mode bit |
| colour_red | output | 1 | Colour mode bit, 1 = red |
| store_en | output | 1 | Store mode bit |
| wthru_en | output | 1 | Write-through mode bit |
| done | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |

## Verification
Each timed path (coordinate load, intensify, erase, switch to red, switch to green) gets its own directed test. Each test checks that `done` is still low one edge before the expected delay and high on that edge, so a swapped or off-by-one delay shows up. Mode writes use all-ones, colour-flip, same-colour and erase-plus-modes patterns. These separate a stored bit from a self-clearing bit and a real colour change from a rewrite. A second command issued in the middle of a countdown, a clear issued during a countdown, and a command with a foreign device field separate restart, cancel and ignore behaviour.

// File: rtl/pt_display_ctl.sv
module pt_display_ctl #(
  parameter int          DW         = 12,
  parameter logic [5:0]  DEV_ID     = 6'o05,
  parameter int          MOVE_DLY   = 4,
  parameter int          INTENS_DLY = 6,
  parameter int          ERASE_DLY  = 40,
  parameter int          RED_DLY    = 12,
  parameter int          GREEN_DLY  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [11:0]   cmd_op,
  input  logic [DW-1:0] ac_in,
  output logic [DW-1:0] ac_out,
  output logic          ac_drive,
  output logic          ac_clr,
  output logic          skip,
  output logic [DW-1:0] x_pos,
  output logic [DW-1:0] y_pos,
  output logic          intens_pls,
  output logic          erase_pls,
  output logic          chan_sel,
  output logic          colour_red,
  output logic          store_en,
  output logic          wthru_en,
  output logic          done,
  output logic          irq
);
  localparam int M1    = (MOVE_DLY > INTENS_DLY) ? MOVE_DLY : INTENS_DLY;
  localparam int M2    = (RED_DLY > GREEN_DLY) ? RED_DLY : GREEN_DLY;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXD  = (M3 > ERASE_DLY) ? M3 : ERASE_DLY;
  localparam int CW    = $clog2(MAXD + 1);

  logic          hit;
  logic [2:0]    fn;
  logic          ie;
  logic [CW-1:0] cnt;

  assign hit = cmd_valid && (cmd_op[11:9] == 3'o6) && (cmd_op[8:3] == DEV_ID);
  assign fn  = cmd_op[2:0];

  assign skip     = hit && (fn == 3'd2) && done;
  assign ac_clr   = hit && (fn == 3'd6);
  assign ac_drive = hit && (fn == 3'd7);
  assign irq      = ie && done;

  always_comb begin
    ac_out = '0;
    if (ac_drive) begin
      ac_out[11] = done;
      ac_out[5]  = wthru_en;
      ac_out[4]  = store_en;
      ac_out[2]  = colour_red;
      ac_out[1]  = chan_sel;
      ac_out[0]  = ie;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_pos      <= '0;
      y_pos      <= '0;
      ie         <= 1'b0;
      chan_sel   <= 1'b0;
      colour_red <= 1'b0;
      store_en   <= 1'b0;
      wthru_en   <= 1'b0;
      done       <= 1'b0;
      cnt        <= '0;
      intens_pls <= 1'b0;
      erase_pls  <= 1'b0;
    end else begin
      intens_pls <= 1'b0;
      erase_pls  <= 1'b0;
      if (cnt == CW'(1)) begin
        done <= 1'b1;
        cnt  <= '0;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (hit) begin
        case (fn)
          3'd0: begin
            x_pos      <= '0;
            y_pos      <= '0;
            ie         <= 1'b0;
            chan_sel   <= 1'b0;
            colour_red <= 1'b0;
            store_en   <= 1'b0;
            wthru_en   <= 1'b0;
            done       <= 1'b0;
            cnt        <= '0;
          end
          3'd1: done <= 1'b0;
          3'd3: begin
            x_pos <= ac_in;
            done  <= 1'b0;
            cnt   <= CW'(MOVE_DLY);
          end
          3'd4: begin
            y_pos <= ac_in;
            done  <= 1'b0;
            cnt   <= CW'(MOVE_DLY);
          end
          3'd5: begin
            intens_pls <= 1'b1;
            done       <= 1'b0;
            cnt        <= CW'(INTENS_DLY);
          end
          3'd6: begin
            ie         <= ac_in[0];
            chan_sel   <= ac_in[1];
            colour_red <= ac_in[2];
            store_en   <= ac_in[4];
            wthru_en   <= ac_in[5];
            if (ac_in[3]) begin
              erase_pls <= 1'b1;
              done      <= 1'b0;
              cnt       <= CW'(ERASE_DLY);
            end else if (ac_in[2] != colour_red) begin
              done <= 1'b0;
              cnt  <= ac_in[2] ? CW'(RED_DLY) : CW'(GREEN_DLY);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pt_display_ctl_chk.sv
module pt_display_ctl_chk #(
  parameter int         DW     = 12,
  parameter logic [5:0] DEV_ID = 6'o05
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [11:0]   cmd_op,
  input logic [DW-1:0] ac_out,
  input logic          ac_drive,
  input logic          skip,
  input logic [DW-1:0] x_pos,
  input logic          intens_pls,
  input logic          done,
  input logic          irq
);
  logic hit;
  assign hit = cmd_valid && (cmd_op[11:9] == 3'o6) && (cmd_op[8:3] == DEV_ID);

  // R2
  ld_drops_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (cmd_op[2:0] == 3'd3 || cmd_op[2:0] == 3'd4) |=> !done);

  // R3
  intens_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && cmd_op[2:0] == 3'd5 |=> intens_pls);

  // R3
  intens_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intens_pls |=> !intens_pls);

  // R4
  skip_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> done && cmd_valid);

  // R6
  erase_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ac_drive |-> ac_out[3] == 1'b0);

  // R9
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  // R10
  clear_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && cmd_op[2:0] == 3'd0 |=> !done && x_pos == '0);
endmodule

bind pt_display_ctl pt_display_ctl_chk #(.DW(DW), .DEV_ID(DEV_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .ac_out(ac_out), .ac_drive(ac_drive), .skip(skip), .x_pos(x_pos),
  .intens_pls(intens_pls), .done(done), .irq(irq)
);

// File: tb/pt_display_ctl_tb.sv
module pt_display_ctl_tb;
  localparam int MOVE = 4, INTS = 6, ERS = 40, RED = 12, GRN = 9;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [11:0] cmd_op = '0, ac_in = '0;
  logic [11:0] ac_out, x_pos, y_pos;
  logic ac_drive, ac_clr, skip, intens_pls, erase_pls;
  logic chan_sel, colour_red, store_en, wthru_en, done, irq;

  int n_chk = 0, n_bad = 0;
  logic s_skip, s_clr, s_drv;
  logic [11:0] s_ac;

  always #5 clk = ~clk;

  pt_display_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .ac_in(ac_in),
    .ac_out(ac_out), .ac_drive(ac_drive), .ac_clr(ac_clr), .skip(skip),
    .x_pos(x_pos), .y_pos(y_pos), .intens_pls(intens_pls), .erase_pls(erase_pls),
    .chan_sel(chan_sel), .colour_red(colour_red), .store_en(store_en),
    .wthru_en(wthru_en), .done(done), .irq(irq)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %o expected %o", req, act, exp);
    end
  endtask

  task automatic issue(input logic [11:0] op, input logic [11:0] ac);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; ac_in = ac;
    #1;
    s_skip = skip; s_clr = ac_clr; s_drv = ac_drive; s_ac = ac_out;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; ac_in = '0;
  endtask

  task automatic expect_delay(input int d, input string req);
    check(req, {11'd0, done}, 12'd0);
    for (int i = 1; i < d; i++) @(negedge clk);
    check(req, {11'd0, done}, 12'd0);
    @(negedge clk);
    check(req, {11'd0, done}, 12'd1);
  endtask

  task automatic t_reset;
    check("R1", {10'd0, done, irq}, 12'd0);
    check("R1", x_pos | y_pos, 12'd0);
    issue(12'o6057, 12'o0);
    check("R1", s_ac, 12'o0000);
  endtask

  task automatic t_load_xy;
    issue(12'o6053, 12'o1234);
    check("R2", x_pos, 12'o1234);
    expect_delay(MOVE, "R2");
    issue(12'o6054, 12'o7777);
    check("R2", y_pos, 12'o7777);
    expect_delay(MOVE, "R2");
  endtask

  task automatic t_skip;
    issue(12'o6052, 12'o0);
    check("R4", {11'd0, s_skip}, 12'd1);
    issue(12'o6051, 12'o0);
    check("R4", {11'd0, done}, 12'd0);
    issue(12'o6052, 12'o0);
    check("R4", {11'd0, s_skip}, 12'd0);
  endtask

  task automatic t_intens;
    issue(12'o6055, 12'o0);
    check("R3", {11'd0, intens_pls}, 12'd1);
    @(negedge clk);
    check("R3", {11'd0, intens_pls}, 12'd0);
    check("R3", {11'd0, done}, 12'd0);
    for (int i = 2; i < INTS; i++) @(negedge clk);
    check("R3", {11'd0, done}, 12'd0);
    @(negedge clk);
    check("R3", {11'd0, done}, 12'd1);
  endtask

  task automatic t_status;
    issue(12'o6056, 12'o0067);
    check("R5", {11'd0, s_clr}, 12'd1);
    check("R5", {8'd0, wthru_en, store_en, colour_red, chan_sel}, 12'b1111);
    check("R9", {11'd0, irq}, 12'd0);
    expect_delay(RED, "R8");
    check("R9", {11'd0, irq}, 12'd1);
    issue(12'o6057, 12'o0);
    check("R6", {11'd0, s_drv}, 12'd1);
    check("R6", s_ac, 12'o4067);
    issue(12'o6056, 12'o0067);
    check("R8", {11'd0, done}, 12'd1);
    issue(12'o6056, 12'o0063);
    expect_delay(GRN, "R8");
  endtask

  task automatic t_erase;
    issue(12'o6056, 12'o0073);
    check("R7", {11'd0, erase_pls}, 12'd1);
    expect_delay(ERS, "R7");
    check("R7", {11'd0, erase_pls}, 12'd0);
    issue(12'o6057, 12'o0);
    check("R7", s_ac, 12'o4063);
  endtask

  task automatic t_restart;
    issue(12'o6053, 12'o0001);
    @(negedge clk);
    issue(12'o6055, 12'o0);
    expect_delay(INTS, "R12");
  endtask

  task automatic t_other;
    issue(12'o6153, 12'o0555);
    check("R11", x_pos, 12'o0001);
    check("R11", {11'd0, done}, 12'd1);
    issue(12'o6156, 12'o0000);
    check("R11", {11'd0, s_clr}, 12'd0);
    check("R11", {11'd0, colour_red}, 12'd0);
    check("R11", {11'd0, irq}, 12'd1);
  endtask

  task automatic t_clear;
    issue(12'o6053, 12'o0707);
    issue(12'o6050, 12'o0);
    check("R10", x_pos | y_pos, 12'd0);
    check("R10", {11'd0, done}, 12'd0);
    for (int i = 0; i < MOVE + 4; i++) @(negedge clk);
    check("R10", {11'd0, done}, 12'd0);
    issue(12'o6057, 12'o0);
    check("R10", s_ac, 12'o0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load_xy;
    t_skip;
    t_intens;
    t_status;
    t_erase;
    t_restart;
    t_other;
    t_clear;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule